// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block produces the read-side control waveforms for an external static memory bus. A read request carries a chip-select index and an address. The block drives the address and one active-low select line for the addressed device, plus one shared active-low read strobe. It captures the data the memory returns and reports completion with a one-clock done pulse. All timing is counted in controller clock cycles. The timing set is picked by the request's chip-select index.

For each chip select, a small register file holds five values: a setup and a pulse length for the read strobe, a setup and a pulse length for the select line, and one total cycle length. Hold times are never stored. Each strobe's hold is whatever remains of the total cycle after its setup and pulse. If setup plus pulse is longer than the programmed total, that strobe's hold becomes zero and the cycle grows to fit it.

A new request is taken while the block is idle or in the last clock of the current cycle, so consecutive reads follow each other with no gap. If a strobe has zero setup and zero hold, it stays low without a break across back-to-back reads.

Top module: `smcrd_seq`

## Requirements
- R1: After reset `memRdN` is 1, `memCsN` is all ones, `memAddr` is 0, `rdDone` is 0 and `reqReady` is 1.
- R2: A clock with `cfgWrEn` high writes the low bits of `cfgData` into the entry selected by `cfgCs`. The field is chosen by `cfgField`: 0 read setup (6 bits), 1 read pulse (7 bits), 2 select setup (6 bits), 3 select pulse (7 bits), 4 total cycle (7 bits). Codes 5 to 7 change nothing, and the other chip selects' entries are left untouched.
- R3: Clock t=0 is the first clock after the accepting edge. `memRdN` is 0 exactly in clocks t with readSetup <= t < readSetup+readPulse.
- R4: `memCsN[cs]` is 0 exactly in clocks t with selSetup <= t < selSetup+selPulse. Every other select line stays 1, so at most one line is ever low.
- R5: The cycle lasts E = max(cycle, readSetup+readPulse, selSetup+selPulse, 1) clocks. `memAddr` shows the request address from t=0 and keeps it until the next request is accepted.
- R6: `rdData` takes `memData` on the edge that ends clock readSetup+readPulse-1. If readPulse is 0, `rdData` does not change.
- R7: `rdDone` is 1 in clock t=E only, which is the clock right after the cycle's last clock.
- R8: `reqReady` is 1 while idle and in clock t=E-1 of a cycle, and 0 otherwise. A request is taken on an edge where `reqValid` and `reqReady` are both 1. A request taken in clock E-1 starts its t=0 in the very next clock.
- R9: Suppose a strobe has zero setup and its setup plus pulse is at least the total cycle. Then during back-to-back reads to the same chip select, that strobe stays 0 in every clock of both cycles.
- R10: The timing values are sampled when a request is accepted. A register write made during a cycle only affects reads accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Timing register write enable |
| cfgCs | input | 2 | Chip select whose timing entry is written |
| cfgField | input | 3 | Field code of the write |
| cfgData | input | 8 | Write value (low bits used) |
| reqValid | input | 1 | Read request present |
| reqCs | input | 2 | Chip select of the request |
| reqAddr | input | 16 | Address of the request |
| reqReady | output | 1 | Request can be accepted this clock |
| memAddr | output | 16 | Memory address bus |
| memCsN | output | 4 | Active-low select lines, one per chip select |
| memRdN | output | 1 | Active-low read strobe |
| memData | input | 16 | Read data from memory |
| rdData | output | 16 | Captured read data |
| rdDone | output | 1 | One-clock completion pulse |

## Verification
The hardest cases to reach from the ports are the clock where one cycle hands over to the next and a write that lands in the middle of a cycle.

- **Back-to-back reads.** The bench holds `reqValid` high through a whole cycle and changes the address during it. This makes the second read be taken exactly in the last clock of the first. The bench then checks that the strobe and the select line never rise between the two reads, and that the address switches at the expected clock.
- **Mid-cycle write.** A register write is driven while a read is running. The current cycle must keep its length, and only the following read may use the new value.
- **Sweep.** A sweep over every combination of small setup, pulse and cycle values covers the clamped-hold cases. It also writes the unused field codes and a different chip select's entry before each read.

// File: rtl/smcrd_pkg.sv
package smcrd_pkg;
  localparam int SETUP_W = 6;
  localparam int PULSE_W = 7;
  localparam int CYCLE_W = 7;
  localparam int CNT_W   = ((PULSE_W > CYCLE_W) ? PULSE_W : CYCLE_W) + 1;

  typedef struct packed {
    logic [SETUP_W-1:0] rdSetup;
    logic [PULSE_W-1:0] rdPulse;
    logic [SETUP_W-1:0] csSetup;
    logic [PULSE_W-1:0] csPulse;
    logic [CYCLE_W-1:0] cycle;
  } timing_t;

  typedef enum logic [2:0] {
    FLD_RD_SETUP = 3'd0,
    FLD_RD_PULSE = 3'd1,
    FLD_CS_SETUP = 3'd2,
    FLD_CS_PULSE = 3'd3,
    FLD_CYCLE    = 3'd4
  } field_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic rdAssert;
    logic csAssert;
    logic cycleEnd;
  } strobe_t;
endpackage

// File: rtl/smcrd_cfg_regs.sv
module smcrd_cfg_regs
  import smcrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CFG_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [CS_W-1:0] cfgCs,
  input  logic [2:0]      cfgField,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [CS_W-1:0] selCs,
  output timing_t         selTiming
);
  localparam timing_t RESET_VAL = '{rdSetup: '0, rdPulse: PULSE_W'(1),
                                    csSetup: '0, csPulse: PULSE_W'(1),
                                    cycle: CYCLE_W'(1)};

  timing_t regs [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic hit;
    assign hit = cfgWrEn && (cfgCs == CS_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[i] <= RESET_VAL;
      end else if (hit) begin
        case (cfgField)
          FLD_RD_SETUP: regs[i].rdSetup <= cfgData[SETUP_W-1:0];
          FLD_RD_PULSE: regs[i].rdPulse <= cfgData[PULSE_W-1:0];
          FLD_CS_SETUP: regs[i].csSetup <= cfgData[SETUP_W-1:0];
          FLD_CS_PULSE: regs[i].csPulse <= cfgData[PULSE_W-1:0];
          FLD_CYCLE:    regs[i].cycle   <= cfgData[CYCLE_W-1:0];
          default: ;
        endcase
      end
    end

    // R2
    cfg_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgWrEn || cfgCs != CS_W'(i)) |=> $stable(regs[i]));
  end

  assign selTiming = regs[selCs];
endmodule

// File: rtl/smcrd_ctrl.sv
module smcrd_ctrl
  import smcrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [CS_W-1:0] reqCs,
  input  timing_t         selTiming,
  output logic            reqReady,
  output logic [CS_W-1:0] curCs,
  output strobe_t         strobes
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  timing_t          lat;
  logic [CNT_W-1:0] rdStart, rdEnd, csStart, csEnd, cycLen, span1, span2, effLen;
  logic             last, accept;

  always_comb begin
    rdStart = CNT_W'(lat.rdSetup);
    csStart = CNT_W'(lat.csSetup);
    rdEnd   = rdStart + CNT_W'(lat.rdPulse);
    csEnd   = csStart + CNT_W'(lat.csPulse);
    cycLen  = CNT_W'(lat.cycle);
    span1   = (cycLen > rdEnd) ? cycLen : rdEnd;
    span2   = (span1 > csEnd) ? span1 : csEnd;
    effLen  = (span2 == '0) ? CNT_W'(1) : span2;
  end

  assign last     = busy && (cnt == effLen - CNT_W'(1));
  assign reqReady = !busy || last;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      lat   <= '0;
      curCs <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      lat   <= selTiming;
      curCs <= reqCs;
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.load     = accept;
    strobes.rdAssert = busy && (cnt >= rdStart) && (cnt < rdEnd);
    strobes.csAssert = busy && (cnt >= csStart) && (cnt < csEnd);
    strobes.capture  = busy && (lat.rdPulse != '0) && (cnt == rdEnd - CNT_W'(1));
    strobes.cycleEnd = last;
  end

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < effLen));

  // R8
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && cnt == '0));

  // R10
  timing_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> $stable(lat));
endmodule

// File: rtl/smcrd_datapath.sv
module smcrd_datapath
  import smcrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [CS_W-1:0]   curCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRdN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      rdData  <= '0;
      rdDone  <= 1'b0;
    end else begin
      if (strobes.load)    memAddr <= reqAddr;
      if (strobes.capture) rdData  <= memData;
      rdDone <= strobes.cycleEnd;
    end
  end

  assign memRdN = !strobes.rdAssert;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csLine
    assign memCsN[i] = !(strobes.csAssert && (curCs == CS_W'(i)));
  end

  // R4
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(memAddr));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(rdData));
endmodule

// File: rtl/smcrd_seq.sv
module smcrd_seq
  import smcrd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CS_W-1:0]   cfgCs,
  input  logic [2:0]        cfgField,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              reqValid,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRdN,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  timing_t         selTiming;
  strobe_t         strobes;
  logic [CS_W-1:0] curCs;

  smcrd_cfg_regs #(.NUM_CS(NUM_CS), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgCs(cfgCs),
    .cfgField(cfgField), .cfgData(cfgData), .selCs(reqCs),
    .selTiming(selTiming)
  );

  smcrd_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCs(reqCs),
    .selTiming(selTiming), .reqReady(reqReady), .curCs(curCs),
    .strobes(strobes)
  );

  smcrd_datapath #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curCs(curCs),
    .reqAddr(reqAddr), .memData(memData), .memAddr(memAddr),
    .memCsN(memCsN), .memRdN(memRdN), .rdData(rdData), .rdDone(rdDone)
  );
endmodule

// File: tb/smcrd_seq_tb.sv
`timescale 1ns/1ps
module smcrd_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgCs = '0;
  logic [2:0] cfgField = '0;
  logic [7:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic [1:0] reqCs = '0;
  logic [15:0] reqAddr = '0;
  logic reqReady;
  logic [15:0] memAddr;
  logic [3:0] memCsN;
  logic memRdN;
  logic [15:0] memData = '0;
  logic [15:0] rdData;
  logic rdDone;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] expRd = '0;

  always #2.5 clk = ~clk;

  smcrd_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgCs(cfgCs),
    .cfgField(cfgField), .cfgData(cfgData), .reqValid(reqValid),
    .reqCs(reqCs), .reqAddr(reqAddr), .reqReady(reqReady),
    .memAddr(memAddr), .memCsN(memCsN), .memRdN(memRdN),
    .memData(memData), .rdData(rdData), .rdDone(rdDone)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input logic [15:0] a, input int t);
    return a * 16'd3 + 16'(t * 257) + 16'h5A;
  endfunction

  // vector {rdN, csN[3:0], addr[15:0], done, ready}
  function automatic logic [31:0] vec(input logic r, input logic [3:0] c,
      input logic [15:0] a, input logic d, input logic y);
    return {9'b0, r, c, a, d, y};
  endfunction

  task automatic writeCfg(input int cs, input int fld, input int val);
    cfgWrEn = 1'b1; cfgCs = 2'(cs); cfgField = 3'(fld); cfgData = 8'(val);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setCfg(input int cs, input int rs, input int rp, input int ss,
                        input int sp, input int cyc);
    writeCfg(cs, 0, rs); writeCfg(cs, 1, rp); writeCfg(cs, 2, ss);
    writeCfg(cs, 3, sp); writeCfg(cs, 4, cyc);
  endtask

  // Single read; optional mid-cycle write of a new total cycle value (R10)
  task automatic runRead(input int cs, input logic [15:0] addr, input int rs,
      input int rp, input int ss, input int sp, input int cyc,
      input bit midWrite, input int newCyc);
    int e;
    logic [31:0] act, exp;
    e = cyc;
    if (rs + rp > e) e = rs + rp;
    if (ss + sp > e) e = ss + sp;
    if (e == 0) e = 1;
    check(reqReady == 1'b1, "R8 idle ready", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqCs = 2'(cs); reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    for (int t = 0; t < e; t++) begin
      logic r;
      logic [3:0] c;
      memData = pat(addr, t);
      if (midWrite && t == 1) begin
        cfgWrEn = 1'b1; cfgCs = 2'(cs); cfgField = 3'd4; cfgData = 8'(newCyc);
      end else begin
        cfgWrEn = 1'b0;
      end
      r = !(t >= rs && t < rs + rp);
      c = 4'hF;
      if (t >= ss && t < ss + sp) c[cs] = 1'b0;
      exp = vec(r, c, addr, 1'b0, (t == e - 1));
      act = vec(memRdN, memCsN, memAddr, rdDone, reqReady);
      check(act == exp, "R3/R4/R5/R8 waveform", act, exp);
      if (rp > 0 && t == rs + rp - 1) expRd = pat(addr, t);
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    exp = vec(1'b1, 4'hF, addr, 1'b1, 1'b1);
    act = vec(memRdN, memCsN, memAddr, rdDone, reqReady);
    check(act == exp, "R7 done clock", act, exp);
    check(rdData == expRd, "R6 captured data", 32'(rdData), 32'(expRd));
    @(negedge clk);
    check(rdDone == 1'b0, "R7 single pulse", 32'(rdDone), 32'd0);
  endtask

  // Two back-to-back reads held by reqValid; rdSeq is the expected memRdN per clock
  task automatic runPair(input int cs, input int e, input logic [15:0] a0,
      input logic [15:0] a1, input logic [15:0] rdSeq, input logic [15:0] csSeq,
      input string req);
    logic [31:0] act, exp;
    logic [3:0] c;
    reqValid = 1'b1; reqCs = 2'(cs); reqAddr = a0;
    @(negedge clk);
    reqAddr = a1;
    for (int t = 0; t < 2 * e; t++) begin
      if (t == e) reqValid = 1'b0;
      c = 4'hF;
      c[cs] = csSeq[t];
      exp = vec(rdSeq[t], c, (t < e) ? a0 : a1, (t == e), ((t % e) == e - 1));
      act = vec(memRdN, memCsN, memAddr, rdDone, reqReady);
      check(act == exp, req, act, exp);
      @(negedge clk);
    end
    exp = vec(1'b1, 4'hF, a1, 1'b1, 1'b1);
    act = vec(memRdN, memCsN, memAddr, rdDone, reqReady);
    check(act == exp, "R7 second done", act, exp);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n = 0;
    int cycs[4] = '{0, 1, 3, 5};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vec(memRdN, memCsN, memAddr, rdDone, reqReady) == vec(1'b1, 4'hF, 16'h0, 1'b0, 1'b1),
          "R1 reset", vec(memRdN, memCsN, memAddr, rdDone, reqReady),
          vec(1'b1, 4'hF, 16'h0, 1'b0, 1'b1));
    rstN = 1'b1;
    @(negedge clk);

    // Sweep: clamped hold, field decode, chip-select isolation (R2)
    for (int rs = 0; rs < 3; rs++)
      for (int rp = 0; rp < 3; rp++)
        for (int ss = 0; ss < 3; ss++)
          for (int sp = 0; sp < 3; sp++)
            for (int ci = 0; ci < 4; ci++) begin
              int cs = n % 4;
              setCfg(cs, rs, rp, ss, sp, cycs[ci]);
              writeCfg(cs, 5 + (n % 3), 8'h7F);      // R2 unused code ignored
              writeCfg((cs + 1) % 4, 4, 8'h7F);      // R2 other entry untouched
              writeCfg((cs + 1) % 4, 0, 8'h3F);
              runRead(cs, 16'(n * 37 + 1), rs, rp, ss, sp, cycs[ci], 1'b0, 0);
              n++;
            end

    // R9: zero setup, clamped zero hold, continuous strobes across two reads
    setCfg(1, 0, 4, 0, 4, 2);
    runPair(1, 4, 16'h1234, 16'h4321, 16'h0000, 16'h0000, "R9 continuous strobes");
    // R8: gapless handover with setup, strobes do rise between reads
    setCfg(3, 1, 2, 1, 2, 3);
    runPair(3, 3, 16'hAAAA, 16'h5555, 16'b1111_1111_1100_1001,
            16'b1111_1111_1100_1001, "R8 gapless handover");

    // R10: write during a cycle does not change it, next read uses it
    setCfg(2, 1, 2, 0, 4, 5);
    runRead(2, 16'h0F0F, 1, 2, 0, 4, 5, 1'b1, 9);
    runRead(2, 16'hF0F0, 1, 2, 0, 4, 9, 1'b0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule